// File: doc/BRIEF.md
# Power-Down Mode Controller

This block sits beside a processor core and decides when the core runs and when it rests. The core sends a one-cycle strobe when it executes its sleep instruction. At that moment the controller looks at a standby-select bit in its small control register. With the bit clear, it enters a light sleep: the CPU halts, but the system clock and the peripherals keep running. With the bit set, it enters deep standby: the CPU, the peripherals and the master clock all stop. A second register bit decides whether the I/O ports float to high impedance during standby. In sleep the ports always keep their levels.

Each low-power state has its own set of wake sources. Sleep ends on any interrupt, on a DMA address error or on a non-maskable interrupt. Standby ends only on the non-maskable interrupt. On that exit the master clock comes back first, and the CPU and peripherals stay held for a settling window of programmable length. When the core is released it receives a one-cycle wake pulse. It can then resume after the sleep instruction or take the waking exception. A power-on or manual reset returns the block to run from any state. CPU registers and RAM are never touched, so their contents are kept.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After power-on reset, pd_mode is 0 (run encoding), cpu_halt is 0, sys_clk_en and periph_clk_en are 1, port_hiz is 0, wake_pulse is 0 and reg_rdata is 0.
- R2: The control register has two bits: bit 0 selects standby and bit 1 enables port high impedance. In run, a write with reg_wr high updates reg_rdata on the next cycle.
- R3: A sleep_req in run with bit 0 at 0 gives, one cycle later, pd_mode 1 (sleep): cpu_halt 1, sys_clk_en 1, periph_clk_en 1 and port_hiz 0, whatever the value of bit 1.
- R4: A sleep_req in run with bit 0 at 1 gives, one cycle later, pd_mode 2 (standby): cpu_halt 1, sys_clk_en 0 and periph_clk_en 0.
- R5: In standby, port_hiz equals register bit 1.
- R6: In sleep, any one of irq, dma_err or nmi returns pd_mode to 0 one cycle later.
- R7: In standby, irq and dma_err have no effect. nmi moves the block one cycle later to pd_mode 3 (settling): sys_clk_en 1, periph_clk_en 0, cpu_halt 1 and port_hiz 0.
- R8: The settling state lasts exactly SETTLE_CYCLES cycles and then returns to run.
- R9: wake_pulse is high for exactly the first run cycle after leaving sleep or settling, and never after a reset.
- R10: Register writes in sleep, standby or settling are ignored.
- R11: A manual reset from any state returns pd_mode to 0 one cycle later, clears both register bits and raises no wake pulse.
- R12: sleep_req outside run, and nmi during settling, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| sleep_req | input | 1 | Sleep instruction strobe from the core |
| irq | input | 1 | Any maskable interrupt request |
| dma_err | input | 1 | DMA address error |
| nmi | input | 1 | Non-maskable interrupt |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 2 | Write data: bit 0 standby select, bit 1 port high impedance |
| reg_rdata | output | 2 | Current control register value |
| pd_mode | output | 2 | 0 run, 1 sleep, 2 standby, 3 settling |
| cpu_halt | output | 1 | Holds the CPU |
| sys_clk_en | output | 1 | Master clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| port_hiz | output | 1 | Drives I/O ports to high impedance |
| wake_pulse | output | 1 | One-cycle resume indication to the core |

## Verification
Sleep entry is tried with each of the three wake sources in turn. This shows that every legal source is decoded and none is missed. Standby entry is tried with the high-impedance bit both clear and set. While in standby the bench sends ordinary interrupts and DMA errors, which separates a correct wake filter from one that copies the sleep rules. The settling window is measured cycle by cycle to catch off-by-one errors in the counter. Writes during low-power states and a manual reset from standby then check that the register is protected and that it clears.

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       man_rst,
  input  logic       sleep_req,
  input  logic       irq,
  input  logic       dma_err,
  input  logic       nmi,
  input  logic       reg_wr,
  input  logic [1:0] reg_wdata,
  output logic [1:0] reg_rdata,
  output logic [1:0] pd_mode,
  output logic       cpu_halt,
  output logic       sys_clk_en,
  output logic       periph_clk_en,
  output logic       port_hiz,
  output logic       wake_pulse
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {RUN = 2'd0, NAP = 2'd1, DEEP = 2'd2, SETTLE = 2'd3} st_t;

  st_t            st;
  logic           stby_sel, hiz_sel, wake_q;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st       <= RUN;
      stby_sel <= 1'b0;
      hiz_sel  <= 1'b0;
      wake_q   <= 1'b0;
      cnt      <= '0;
    end else if (man_rst) begin
      st       <= RUN;
      stby_sel <= 1'b0;
      hiz_sel  <= 1'b0;
      wake_q   <= 1'b0;
      cnt      <= '0;
    end else begin
      wake_q <= 1'b0;
      case (st)
        RUN: begin
          if (reg_wr) begin
            stby_sel <= reg_wdata[0];
            hiz_sel  <= reg_wdata[1];
          end
          if (sleep_req) st <= stby_sel ? DEEP : NAP;
        end
        NAP: if (irq || dma_err || nmi) begin
          st     <= RUN;
          wake_q <= 1'b1;
        end
        DEEP: if (nmi) begin
          st  <= SETTLE;
          cnt <= CNT_LOAD;
        end
        SETTLE: if (cnt == '0) begin
          st     <= RUN;
          wake_q <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= RUN;
      endcase
    end
  end

  assign reg_rdata     = {hiz_sel, stby_sel};
  assign pd_mode       = st;
  assign cpu_halt      = (st != RUN);
  assign sys_clk_en    = (st != DEEP);
  assign periph_clk_en = (st == RUN) || (st == NAP);
  assign port_hiz      = (st == DEEP) && hiz_sel;
  assign wake_pulse    = wake_q;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       man_rst,
  input logic       sleep_req,
  input logic       irq,
  input logic       dma_err,
  input logic       nmi,
  input logic       reg_wr,
  input logic [1:0] reg_wdata,
  input logic [1:0] reg_rdata,
  input logic [1:0] pd_mode,
  input logic       cpu_halt,
  input logic       sys_clk_en,
  input logic       periph_clk_en,
  input logic       port_hiz,
  input logic       wake_pulse
);
  assert_reg_write_R2: assert property (@(posedge clk) disable iff (!por_n)
    (pd_mode == 2'd0 && reg_wr && !man_rst) |=> (reg_rdata == $past(reg_wdata)));

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!por_n)
    (pd_mode == 2'd0 && sleep_req && !reg_rdata[0] && !man_rst) |=>
      (cpu_halt && sys_clk_en && periph_clk_en && !port_hiz));

  assert_standby_entry_R4: assert property (@(posedge clk) disable iff (!por_n)
    (pd_mode == 2'd0 && sleep_req && reg_rdata[0] && !man_rst) |=>
      (cpu_halt && !sys_clk_en && !periph_clk_en));

  assert_hiz_only_standby_R5: assert property (@(posedge clk) disable iff (!por_n)
    port_hiz |-> (!sys_clk_en && reg_rdata[1]));

  assert_sleep_wake_R6: assert property (@(posedge clk) disable iff (!por_n)
    (pd_mode == 2'd1 && (irq || dma_err || nmi)) |=> (pd_mode == 2'd0));

  assert_standby_filter_R7: assert property (@(posedge clk) disable iff (!por_n)
    (pd_mode == 2'd2 && !nmi && !man_rst) |=> (pd_mode == 2'd2));

  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!por_n)
    wake_pulse |=> !wake_pulse);

  assert_write_blocked_R10: assert property (@(posedge clk) disable iff (!por_n)
    (cpu_halt && reg_wr && !man_rst) |=> $stable(reg_rdata));

  assert_man_reset_R11: assert property (@(posedge clk) disable iff (!por_n)
    man_rst |=> (pd_mode == 2'd0 && reg_rdata == 2'b00 && !wake_pulse));
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_chk (.*);

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;
  localparam int SETTLE = 5;

  logic clk = 1'b0, por_n = 1'b0, man_rst = 1'b0, sleep_req = 1'b0;
  logic irq = 1'b0, dma_err = 1'b0, nmi = 1'b0, reg_wr = 1'b0;
  logic [1:0] reg_wdata = 2'b00;
  logic [1:0] reg_rdata, pd_mode;
  logic cpu_halt, sys_clk_en, periph_clk_en, port_hiz, wake_pulse;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  pwrdn_ctrl #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .por_n(por_n), .man_rst(man_rst), .sleep_req(sleep_req),
    .irq(irq), .dma_err(dma_err), .nmi(nmi), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd_mode(pd_mode),
    .cpu_halt(cpu_halt), .sys_clk_en(sys_clk_en), .periph_clk_en(periph_clk_en),
    .port_hiz(port_hiz), .wake_pulse(wake_pulse));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic write_reg(input logic [1:0] v);
    reg_wr = 1'b1; reg_wdata = v; step(); reg_wr = 1'b0;
  endtask

  task automatic do_sleep();
    sleep_req = 1'b1; step(); sleep_req = 1'b0;
  endtask

  task automatic t_reset();
    check("R1", "mode", pd_mode, 0);
    check("R1", "halt", cpu_halt, 0);
    check("R1", "clocks", {sys_clk_en, periph_clk_en}, 3);
    check("R1", "hiz/wake", {port_hiz, wake_pulse}, 0);
    check("R1", "rdata", reg_rdata, 0);
  endtask

  task automatic t_regs();
    write_reg(2'b10); check("R2", "rdata hiz", reg_rdata, 2);
    write_reg(2'b01); check("R2", "rdata stby", reg_rdata, 1);
  endtask

  task automatic t_sleep(input int src);
    write_reg(2'b10);
    do_sleep();
    check("R3", "mode", pd_mode, 1);
    check("R3", "halt/sys/per/hiz", {cpu_halt, sys_clk_en, periph_clk_en, port_hiz}, 4'b1110);
    reg_wr = 1'b1; reg_wdata = 2'b01; sleep_req = 1'b1; step();
    reg_wr = 1'b0; sleep_req = 1'b0;
    check("R12", "sleep_req in sleep", pd_mode, 1);
    check("R10", "write in sleep", reg_rdata, 2);
    irq = (src == 0); dma_err = (src == 1); nmi = (src == 2); step();
    irq = 1'b0; dma_err = 1'b0; nmi = 1'b0;
    check("R6", "wake mode", pd_mode, 0);
    check("R9", "wake pulse", wake_pulse, 1);
    step();
    check("R9", "wake pulse end", wake_pulse, 0);
  endtask

  task automatic t_standby(input logic hz);
    write_reg({hz, 1'b1});
    do_sleep();
    check("R4", "mode", pd_mode, 2);
    check("R4", "halt/sys/per", {cpu_halt, sys_clk_en, periph_clk_en}, 3'b100);
    check("R5", "port_hiz", port_hiz, int'(hz));
    irq = 1'b1; step(); irq = 1'b0;
    check("R7", "irq ignored", pd_mode, 2);
    dma_err = 1'b1; step(); dma_err = 1'b0;
    check("R7", "dma_err ignored", pd_mode, 2);
    check("R9", "no pulse", wake_pulse, 0);
    reg_wr = 1'b1; reg_wdata = {~hz, 1'b0}; step(); reg_wr = 1'b0;
    check("R10", "write in standby", reg_rdata, int'({hz, 1'b1}));
    nmi = 1'b1; step(); nmi = 1'b0;
    check("R7", "settle mode", pd_mode, 3);
    check("R7", "halt/sys/per/hiz", {cpu_halt, sys_clk_en, periph_clk_en, port_hiz}, 4'b1100);
    for (int i = 0; i < SETTLE - 1; i++) begin
      nmi = (i == 0); reg_wr = (i == 1); reg_wdata = 2'b00;
      step();
      nmi = 1'b0; reg_wr = 1'b0;
      if (pd_mode != 2'd3) check("R8", "still settling", pd_mode, 3);
    end
    check("R8", "last settle cycle", pd_mode, 3);
    check("R12", "nmi in settle / R10 write", reg_rdata, int'({hz, 1'b1}));
    step();
    check("R8", "run after settle", pd_mode, 0);
    check("R9", "wake pulse", wake_pulse, 1);
    step();
    check("R9", "pulse end", wake_pulse, 0);
  endtask

  task automatic t_manrst();
    write_reg(2'b11);
    do_sleep();
    check("R4", "standby before reset", pd_mode, 2);
    man_rst = 1'b1; step(); man_rst = 1'b0;
    check("R11", "mode", pd_mode, 0);
    check("R11", "rdata", reg_rdata, 0);
    check("R11", "wake", wake_pulse, 0);
    check("R11", "clocks", {sys_clk_en, periph_clk_en, cpu_halt}, 3'b110);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    por_n = 1'b1;
    step();
    t_reset();
    t_regs();
    t_sleep(0);
    t_sleep(1);
    t_sleep(2);
    t_standby(1'b0);
    t_standby(1'b1);
    t_manrst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule